// File: doc/BRIEF.md
# Multi-Core Power Sequencer

This block brings up to four processor cores in and out of a powered state under software control. Software sees a small 32-bit register bus with an address, a write enable, write data and a combinational read-data return. For each core the block watches a wait-for-interrupt input and drives a power-enable output and an active-high reset output. The physical power switch is not modelled. Its settling time is a programmable count of clock cycles.

Software wakes a core by writing a one into that core's bit of the wake register. The bit stays set while the core powers up, and it clears by itself once the core is running, so software can poll the register until it reads zero. Putting a core to sleep is deferred. Software arms standby in the core's own control register, and the core only powers down once it later raises its wait-for-interrupt input. A packed status word gives each core's state as one of four codes. A free 32-bit debug word is kept and returned, so software can change it with a read-modify-write.

Top module: `core_power_sequencer`

## Requirements
- R1: After reset, core 0 is running (power-enable 1, reset 0) and every other core is in standby (power-enable 0, reset 1). The wake register, every control register and the debug word read zero.
- R2: Writing the wake register (offset 0x10) with bit n set requests power-up of core n. Bit n reads back as 1 while the request is pending and reads 0 again in the same cycle that the core reaches running.
- R3: A core woken from standby reports code 1 (rising) for exactly SETTLE cycles, with power-enable on and reset still asserted. It then reports code 0 (running) and reset is released.
- R4: Writing 3 into bits 1:0 of core n's control register (offset 0x100 + 0x10*n) arms standby, and the register then reads 3. Writing any other value disarms it and it reads 0. An armed core leaves running only in a cycle where its wait-for-interrupt input is high, and the arm clears when power-down starts.
- R5: Standby entry reports code 2 (falling) for exactly SETTLE cycles, with reset asserted and power-enable still on. It then reports code 3 (standby) with power-enable off.
- R6: A wake request for a core that is already running clears its wake bit within two cycles of the write and leaves the core running.
- R7: A wake request that arrives while a core is falling is held, and the bit stays set. The core completes power-down to code 3, enters code 1 in the next cycle, and the bit clears on reaching running.
- R8: The status register (offset 0x40) holds core n's 2-bit code in bits 4n+1:4n. All other bits read zero.
- R9: The debug word (offset 0x180) stores all 32 written bits and returns them unchanged.
- R10: Reads of unmapped offsets, including control slots at or beyond the core count, return zero. Writes to unmapped offsets or to the status register change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_idle | input | NCORE | Per-core wait-for-interrupt indication |
| core_pwr_en | output | NCORE | Per-core power-switch enable |
| core_reset | output | NCORE | Per-core reset, active high |

## Verification
On every cycle the assertions check the legal state successions (standby only to rising, running only to running or falling) and the ordering of power and reset edges. They also check that a wake bit drops only when its core is running, that unused status bits stay zero, and that a debug write lands. Only the bench scenarios can show the exact SETTLE-cycle length of each transition, the deferral of standby until wait-for-interrupt, disarming, the held wake across a power-down, and that unmapped and status writes change nothing.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_RISE = 2'd1,
      PS_FALL = 2'd2,
      PS_OFF  = 2'd3
   } pwr_state_e;

   localparam logic [11:0] OFS_WAKE     = 12'h010;
   localparam logic [11:0] OFS_STATUS   = 12'h040;
   localparam logic [11:0] OFS_CTL_BASE = 12'h100;
   localparam logic [11:0] OFS_DEBUG    = 12'h180;
   localparam int          CTL_STRIDE   = 16;
   localparam int          STAT_STRIDE  = 4;
   localparam logic [1:0]  CTL_STANDBY  = 2'd3;
   localparam int          MAX_CORES    = 4;

endpackage

// File: rtl/pwr_core_seq.sv
module pwr_core_seq
   import pwr_seq_pkg::*;
#(
   parameter int SETTLE   = 16,
   parameter bit START_ON = 1'b0,
   localparam int CNT_W   = $clog2(SETTLE + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wake_req,
   input  logic       stby_req,
   input  logic       core_idle,
   output pwr_state_e state,
   output logic       wake_done,
   output logic       stby_take,
   output logic       pwr_en,
   output logic       core_rst
);

   logic [CNT_W-1:0] cnt;
   logic             cnt_last;

   assign cnt_last = (cnt == CNT_W'(SETTLE - 1));

   always_comb begin
      wake_done = ((state == PS_RUN) && wake_req) || ((state == PS_RISE) && cnt_last);
      stby_take = (state == PS_RUN) && stby_req && core_idle;
      pwr_en    = (state != PS_OFF);
      core_rst  = (state != PS_RUN);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         if (START_ON) state <= PS_RUN;
         else          state <= PS_OFF;
      end else begin
         unique case (state)
            PS_OFF: begin
               if (wake_req) begin
                  state <= PS_RISE;
                  cnt   <= '0;
               end
            end
            PS_RISE: begin
               if (cnt_last) state <= PS_RUN;
               else          cnt   <= cnt + 1'b1;
            end
            PS_RUN: begin
               if (stby_take) begin
                  state <= PS_FALL;
                  cnt   <= '0;
               end
            end
            PS_FALL: begin
               if (cnt_last) state <= PS_OFF;
               else          cnt   <= cnt + 1'b1;
            end
            default: state <= PS_OFF;
         endcase
      end
   end

endmodule

// File: rtl/pwr_reg_file.sv
module pwr_reg_file
   import pwr_seq_pkg::*;
#(
   parameter int NCORE  = 4,
   parameter int ADDR_W = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [31:0]           bus_wdata,
   output logic [31:0]           bus_rdata,
   input  logic [NCORE-1:0][1:0] core_state,
   input  logic [NCORE-1:0]      wake_done,
   input  logic [NCORE-1:0]      stby_take,
   output logic [NCORE-1:0]      wake_pend,
   output logic [NCORE-1:0]      stby_arm,
   output logic [31:0]           dbg_q
);

   logic             hit_wake;
   logic             hit_stat;
   logic             hit_dbg;
   logic [NCORE-1:0] hit_ctl;
   logic [31:0]      stat_word;

   assign hit_wake = (bus_addr == ADDR_W'(OFS_WAKE));
   assign hit_stat = (bus_addr == ADDR_W'(OFS_STATUS));
   assign hit_dbg  = (bus_addr == ADDR_W'(OFS_DEBUG));

   for (genvar n = 0; n < NCORE; n++) begin : g_ctl
      assign hit_ctl[n] = (bus_addr == ADDR_W'(OFS_CTL_BASE) + ADDR_W'(n * CTL_STRIDE));

      always_ff @(posedge clk) begin
         if (!rst_n)                       stby_arm[n] <= 1'b0;
         else if (bus_we && hit_ctl[n])    stby_arm[n] <= (bus_wdata[1:0] == CTL_STANDBY);
         else if (stby_take[n])            stby_arm[n] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wake_pend <= '0;
         dbg_q     <= '0;
      end else begin
         wake_pend <= (wake_pend & ~wake_done)
                    | ((bus_we && hit_wake) ? bus_wdata[NCORE-1:0] : '0);
         if (bus_we && hit_dbg) dbg_q <= bus_wdata;
      end
   end

   always_comb begin
      stat_word = '0;
      for (int n = 0; n < NCORE; n++) stat_word[n*STAT_STRIDE +: 2] = core_state[n];
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_wake) bus_rdata[NCORE-1:0] = wake_pend;
      if (hit_stat) bus_rdata = stat_word;
      if (hit_dbg)  bus_rdata = dbg_q;
      for (int n = 0; n < NCORE; n++)
         if (hit_ctl[n]) bus_rdata[1:0] = stby_arm[n] ? CTL_STANDBY : 2'd0;
   end

endmodule

// File: rtl/core_power_sequencer.sv
module core_power_sequencer
   import pwr_seq_pkg::*;
#(
   parameter int NCORE  = 4,
   parameter int SETTLE = 16,
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NCORE-1:0]  core_idle,
   output logic [NCORE-1:0]  core_pwr_en,
   output logic [NCORE-1:0]  core_reset
);

   if (NCORE < 1 || NCORE > MAX_CORES) begin : g_bad_ncore
      $error("NCORE must lie between 1 and 4");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x180");
   end

   logic [NCORE-1:0][1:0] core_state;
   logic [NCORE-1:0]      wake_done;
   logic [NCORE-1:0]      stby_take;
   logic [NCORE-1:0]      wake_pend;
   logic [NCORE-1:0]      stby_arm;
   logic [31:0]           dbg_q;

   pwr_reg_file #(
      .NCORE  (NCORE),
      .ADDR_W (ADDR_W)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .core_state (core_state),
      .wake_done  (wake_done),
      .stby_take  (stby_take),
      .wake_pend  (wake_pend),
      .stby_arm   (stby_arm),
      .dbg_q      (dbg_q)
   );

   for (genvar n = 0; n < NCORE; n++) begin : g_core
      pwr_state_e st;

      pwr_core_seq #(
         .SETTLE   (SETTLE),
         .START_ON (n == 0)
      ) i_seq (
         .clk       (clk),
         .rst_n     (rst_n),
         .wake_req  (wake_pend[n]),
         .stby_req  (stby_arm[n]),
         .core_idle (core_idle[n]),
         .state     (st),
         .wake_done (wake_done[n]),
         .stby_take (stby_take[n]),
         .pwr_en    (core_pwr_en[n]),
         .core_rst  (core_reset[n])
      );

      assign core_state[n] = st;
   end

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
   import pwr_seq_pkg::*;
#(
   parameter int NCORE  = 4,
   parameter int ADDR_W = 12
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic                  bus_we,
   input logic [31:0]           bus_wdata,
   input logic [31:0]           bus_rdata,
   input logic [NCORE-1:0]      core_pwr_en,
   input logic [NCORE-1:0]      core_reset,
   input logic [NCORE-1:0][1:0] core_state,
   input logic [NCORE-1:0]      wake_pend,
   input logic [31:0]           dbg_q
);

   function automatic logic [31:0] used_mask();
      logic [31:0] m = '0;
      for (int n = 0; n < NCORE; n++) m[n*STAT_STRIDE +: 2] = 2'b11;
      return m;
   endfunction

   localparam logic [31:0] STAT_USED = used_mask();

   // R8
   stat_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_STATUS)) |-> ((bus_rdata & ~STAT_USED) == 32'd0));

   // R9
   dbg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(OFS_DEBUG)) |=> (dbg_q == $past(bus_wdata)));

   for (genvar i = 0; i < NCORE; i++) begin : g_chk
      // R3
      rise_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(core_pwr_en[i]) |-> core_reset[i]);

      // R5
      fall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(core_pwr_en[i]) |-> $past(core_reset[i]));

      // R3
      off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (core_state[i] == PS_OFF) |=> (core_state[i] == PS_OFF || core_state[i] == PS_RISE));

      // R5
      run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (core_state[i] == PS_RUN) |=> (core_state[i] == PS_RUN || core_state[i] == PS_FALL));

      // R2
      wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(wake_pend[i]) |-> (core_state[i] == PS_RUN));
   end

endmodule

bind core_power_sequencer pwr_seq_chk #(
   .NCORE  (NCORE),
   .ADDR_W (ADDR_W)
) i_pwr_seq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_we      (bus_we),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .core_pwr_en (core_pwr_en),
   .core_reset  (core_reset),
   .core_state  (core_state),
   .wake_pend   (wake_pend),
   .dbg_q       (dbg_q)
);

// File: tb/test_core_power_sequencer.sv
`timescale 1ns/1ps
module test_core_power_sequencer;

   localparam int NCORE  = 4;
   localparam int SETTLE = 16;
   localparam int ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_we = 1'b0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCORE-1:0]  core_idle = '0;
   logic [NCORE-1:0]  core_pwr_en;
   logic [NCORE-1:0]  core_reset;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   core_power_sequencer #(
      .NCORE  (NCORE),
      .SETTLE (SETTLE),
      .ADDR_W (ADDR_W)
   ) i_core_power_sequencer (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_we      (bus_we),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .core_idle   (core_idle),
      .core_pwr_en (core_pwr_en),
      .core_reset  (core_reset)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic field(input int n, output logic [31:0] f);
      logic [31:0] s;
      rd(12'h040, s);
      f = 32'((s >> (4 * n)) & 32'h3);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(12'h040, d); chk("R1 R8 status after reset", d, 32'h0000_3330);
      rd(12'h010, d); chk("R1 wake after reset", d, 32'h0);
      rd(12'h180, d); chk("R1 debug after reset", d, 32'h0);
      for (int n = 0; n < NCORE; n++) begin
         rd(12'(12'h100 + 16 * n), d); chk("R1 control after reset", d, 32'h0);
      end
      chk("R1 power enables", 32'(core_pwr_en), 32'h1);
      chk("R1 resets", 32'(core_reset), 32'he);
   endtask

   task automatic t_debug();
      logic [31:0] d;
      wr(12'h180, 32'h0118_0000);
      rd(12'h180, d); chk("R9 debug enables", d, 32'h0118_0000);
      wr(12'h180, d | 32'h0020_0000);
      rd(12'h180, d); chk("R9 debug read-modify-write", d, 32'h0138_0000);
      wr(12'h180, 32'hA5A5_5A5A);
      rd(12'h180, d); chk("R9 debug full word", d, 32'hA5A5_5A5A);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      rd(12'h020, d); chk("R10 unmapped 0x020", d, 32'h0);
      rd(12'h104, d); chk("R10 unmapped 0x104", d, 32'h0);
      rd(12'h140, d); chk("R10 control slot beyond cores", d, 32'h0);
      wr(12'h040, 32'hFFFF_FFFF);
      wr(12'h014, 32'h0000_000F);
      wr(12'h140, 32'h0000_0003);
      step(3);
      rd(12'h040, d); chk("R10 status unchanged by writes", d, 32'h0000_3330);
      rd(12'h010, d); chk("R10 wake unchanged by writes", d, 32'h0);
   endtask

   task automatic t_wake_core1();
      logic [31:0] d;
      wr(12'h010, 32'h2);
      rd(12'h010, d); chk("R2 wake bit set", d, 32'h2);
      step(1);
      field(1, d); chk("R3 rising code", d, 32'h1);
      chk("R3 power on at rise", 32'(core_pwr_en[1]), 32'h1);
      chk("R3 reset held at rise", 32'(core_reset[1]), 32'h1);
      step(SETTLE - 1);
      field(1, d); chk("R3 still rising at last cycle", d, 32'h1);
      rd(12'h010, d); chk("R2 wake bit held during rise", d, 32'h2);
      step(1);
      field(1, d); chk("R3 running after settle", d, 32'h0);
      chk("R3 reset released", 32'(core_reset[1]), 32'h0);
      rd(12'h010, d); chk("R2 wake bit cleared", d, 32'h0);
   endtask

   task automatic t_standby_core1();
      logic [31:0] d;
      wr(12'h110, 32'h3);
      step(4);
      rd(12'h110, d); chk("R4 armed reads 3", d, 32'h3);
      field(1, d); chk("R4 no standby without idle", d, 32'h0);
      core_idle[1] = 1'b1;
      step(1);
      field(1, d); chk("R5 falling code", d, 32'h2);
      chk("R5 reset asserted first", 32'(core_reset[1]), 32'h1);
      chk("R5 power kept during fall", 32'(core_pwr_en[1]), 32'h1);
      rd(12'h110, d); chk("R4 arm cleared at start", d, 32'h0);
      step(SETTLE - 1);
      field(1, d); chk("R5 still falling at last cycle", d, 32'h2);
      step(1);
      field(1, d); chk("R5 standby reached", d, 32'h3);
      chk("R5 power removed", 32'(core_pwr_en[1]), 32'h0);
      core_idle[1] = 1'b0;
   endtask

   task automatic t_disarm_core0();
      logic [31:0] d;
      wr(12'h100, 32'h3);
      wr(12'h100, 32'h1);
      rd(12'h100, d); chk("R4 disarm reads 0", d, 32'h0);
      core_idle[0] = 1'b1;
      step(3);
      field(0, d); chk("R4 disarmed core keeps running", d, 32'h0);
      core_idle[0] = 1'b0;
   endtask

   task automatic t_wake_running();
      logic [31:0] d;
      wr(12'h010, 32'h1);
      step(1);
      rd(12'h010, d); chk("R6 wake of running core cleared", d, 32'h0);
      field(0, d); chk("R6 core stays running", d, 32'h0);
      chk("R6 power stays on", 32'(core_pwr_en[0]), 32'h1);
   endtask

   task automatic t_wake_during_fall();
      logic [31:0] d;
      wr(12'h100, 32'h3);
      core_idle[0] = 1'b1;
      step(1);
      core_idle[0] = 1'b0;
      field(0, d); chk("R7 core 0 falling", d, 32'h2);
      wr(12'h010, 32'h1);
      rd(12'h010, d); chk("R7 wake held while falling", d, 32'h1);
      for (int k = 0; k < 4 * SETTLE; k++) begin
         field(0, d);
         if (d != 32'h2) break;
         step(1);
      end
      chk("R7 standby reached first", d, 32'h3);
      rd(12'h010, d); chk("R7 wake still pending at standby", d, 32'h1);
      step(1);
      field(0, d); chk("R7 rise follows standby", d, 32'h1);
      step(SETTLE);
      field(0, d); chk("R7 running after held wake", d, 32'h0);
      rd(12'h010, d); chk("R7 wake cleared", d, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_unmapped();
      t_debug();
      t_wake_core1();
      t_standby_core1();
      t_disarm_core0();
      t_wake_running();
      t_wake_during_fall();
      finish_run();
   end

   initial begin
      #(5.0 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

endmodule